// File: doc/BRIEF.md
# PWM Fault Trip Handler

This block sits between a PWM generator and its output drivers and takes protective action when any of three already-synchronized fault inputs asserts. Each fault input is set up through a small write-only configuration port to start a cycle-by-cycle trip, to start a latched one-shot trip, or to be ignored. While a trip is active, the block replaces each of the two PWM waveforms, A and B, with a forced value. The forced value is chosen by a two-bit action code, and a separate code applies to each output, each trip type and each counting direction of the PWM timer.

A cycle-by-cycle trip ends by itself. Once every cycle-by-cycle fault has gone away, the trip is released at the next timer event chosen by a configuration bit, either period end or zero. A one-shot trip stays in force until software writes a clear command. The block drives two status flags, one per trip type. It also raises one interrupt pulse per fault input for each trip type, at the moment that fault first appears.

Top module: `pwm_trip_guard`

## Requirements
- R1: Configuration address 0 holds a 2-bit mode for fault i at bits [2i+1:2i]. Code 01 selects cycle-by-cycle, code 10 selects one-shot, and codes 00 and 11 make that fault input have no effect on outputs, status or interrupts.
- R2: In the same cycle that an enabled fault input is high, the outputs, status flags and interrupt pulses reflect the trip. No clock edge is needed between the fault and the override.
- R3: Each action code is 2 bits: 00 passes the raw waveform, 01 forces low, 10 forces high, 11 inverts the raw waveform. An action byte holds A-up at [1:0], A-down at [3:2], B-up at [5:4] and B-down at [7:6]. The up codes apply while `cnt_up_i` is 1 and the down codes while it is 0. Address 1 holds the cycle-by-cycle action byte and address 2 the one-shot action byte.
- R4: After all cycle-by-cycle faults are low, the cycle-by-cycle trip stays active until a cycle in which the selected release event is high, and it is inactive from the following cycle. Address 0 bit 6 selects the event: 0 selects `evt_period_i`, 1 selects `evt_zero_i`. The event that is not selected has no effect.
- R5: A cycle-by-cycle fault that is high in the cycle of the release event keeps the cycle-by-cycle trip active.
- R6: A one-shot trip stays active until a write to address 3 with bit 0 set. If a one-shot fault is high in the cycle of that write, the trip stays active.
- R7: When both trip types are active, the one-shot actions drive the outputs.
- R8: `cbc_active_o` and `ost_active_o` are high exactly while the respective trip is active, counting the cycle in which it is triggered.
- R9: `cbc_irq_o[i]` or `ost_irq_o[i]` (as fault i's mode selects) is high for one cycle when fault i is high and was low in the previous cycle, or when fault i is high in the first cycle after reset.
- R10: A fault input that is high for a single cycle is enough to start a trip, which then persists as R4 and R6 describe.
- R11: After reset all modes are 00, all action codes are 00 and the release select is 0. No trip is active, so the outputs equal the raw waveforms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_i | input | 3 | Synchronized fault levels, high = fault |
| pwm_a_i | input | 1 | Raw waveform A |
| pwm_b_i | input | 1 | Raw waveform B |
| cnt_up_i | input | 1 | Timer direction, 1 = counting up |
| evt_period_i | input | 1 | Timer period-end event |
| evt_zero_i | input | 1 | Timer zero event |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration address |
| cfg_wdata_i | input | 8 | Configuration write data |
| pwm_a_o | output | 1 | Protected waveform A |
| pwm_b_o | output | 1 | Protected waveform B |
| cbc_active_o | output | 1 | Cycle-by-cycle trip active |
| ost_active_o | output | 1 | One-shot trip active |
| cbc_irq_o | output | 3 | Per-fault cycle-by-cycle interrupt pulses |
| ost_irq_o | output | 3 | Per-fault one-shot interrupt pulses |

## Verification
The bench targets the release boundary. It pulses the unselected event while a cycle-by-cycle fault is clear, which a design with the event select inverted would treat as a release. It holds the fault across the selected event, which a design that releases unconditionally would drop for one cycle. It issues the one-shot clear in the same cycle as a fresh one-shot fault, which a design that lets the clear win would lose. It drives single-cycle fault pulses, which a design that registers the fault before acting would show a cycle late. It runs both trips together, which exposes any reversed priority through the forced levels. Random direction and raw waveforms reach every action code, so an up/down or A/B field swap shows up as a wrong output level.

// File: rtl/trip_pkg.sv
package trip_pkg;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_FLIP = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        TRIP_NONE = 2'b00,
        TRIP_CBC  = 2'b01,
        TRIP_OST  = 2'b10,
        TRIP_OFF  = 2'b11
    } trip_e;

    // packed: first member is most significant, so a_up lands in [1:0]
    typedef struct packed {
        act_e b_dn;
        act_e b_up;
        act_e a_dn;
        act_e a_up;
    } act_set_t;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_CBC  = 2'd1;
    localparam logic [1:0] ADDR_OST  = 2'd2;
    localparam logic [1:0] ADDR_CMD  = 2'd3;

    function automatic logic apply_act(input act_e code, input logic raw);
        case (code)
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            ACT_FLIP: return ~raw;
            default:  return raw;
        endcase
    endfunction

endpackage

// File: rtl/trip_cfg_regs.sv
module trip_cfg_regs
    import trip_pkg::*;
#(
    parameter int NUM_FAULTS = 3,
    parameter int ADDR_W     = 2,
    parameter int DATA_W     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [2*NUM_FAULTS-1:0] mode_o,
    output logic                    rel_zero_o,
    output act_set_t                cbc_act_o,
    output act_set_t                ost_act_o,
    output logic                    ost_clr_o
);

    localparam int MODE_W = 2 * NUM_FAULTS;
    localparam int SEL_BIT = MODE_W;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              rel_zero;
        act_set_t          cbc;
        act_set_t          ost;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            case (addr_i)
                ADDR_MODE: begin
                    cfg_d.mode     = wdata_i[MODE_W-1:0];
                    cfg_d.rel_zero = wdata_i[SEL_BIT];
                end
                ADDR_CBC: cfg_d.cbc = act_set_t'(wdata_i[7:0]);
                ADDR_OST: cfg_d.ost = act_set_t'(wdata_i[7:0]);
                default:  cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mode_o     = cfg_q.mode;
    assign rel_zero_o = cfg_q.rel_zero;
    assign cbc_act_o  = cfg_q.cbc;
    assign ost_act_o  = cfg_q.ost;
    assign ost_clr_o  = we_i && (addr_i == ADDR_CMD) && wdata_i[0];

    AST_MODE_STABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(mode_o)) else $error("mode changed without write"); // R1

endmodule

// File: rtl/trip_latch.sv
module trip_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rel_i,
    output logic on_o
);

    typedef struct packed {
        logic held;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)      st_d.held = 1'b1;
        else if (rel_i) st_d.held = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on_o = set_i | st_q.held;

    AST_TRIP_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> on_o) else $error("trip not captured"); // R10

    AST_TRIP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (on_o && !rel_i) |=> on_o) else $error("trip dropped early"); // R4

    AST_TRIP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_i && !set_i) |=> (on_o == set_i)) else $error("trip not released"); // R5

endmodule

// File: rtl/trip_override.sv
module trip_override
    import trip_pkg::*;
(
    input  logic raw_i,
    input  logic up_i,
    input  logic cbc_on_i,
    input  logic ost_on_i,
    input  act_e cbc_up_i,
    input  act_e cbc_dn_i,
    input  act_e ost_up_i,
    input  act_e ost_dn_i,
    output logic out_o
);

    act_e cbc_sel, ost_sel;

    always_comb begin
        cbc_sel = up_i ? cbc_up_i : cbc_dn_i;
        ost_sel = up_i ? ost_up_i : ost_dn_i;
        if (ost_on_i)      out_o = apply_act(ost_sel, raw_i);
        else if (cbc_on_i) out_o = apply_act(cbc_sel, raw_i);
        else               out_o = raw_i;
    end

endmodule

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard
    import trip_pkg::*;
#(
    parameter int NUM_FAULTS = 3,
    parameter int ADDR_W     = 2,
    parameter int DATA_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FAULTS-1:0] fault_i,
    input  logic                  pwm_a_i,
    input  logic                  pwm_b_i,
    input  logic                  cnt_up_i,
    input  logic                  evt_period_i,
    input  logic                  evt_zero_i,
    input  logic                  cfg_we_i,
    input  logic [ADDR_W-1:0]     cfg_addr_i,
    input  logic [DATA_W-1:0]     cfg_wdata_i,
    output logic                  pwm_a_o,
    output logic                  pwm_b_o,
    output logic                  cbc_active_o,
    output logic                  ost_active_o,
    output logic [NUM_FAULTS-1:0] cbc_irq_o,
    output logic [NUM_FAULTS-1:0] ost_irq_o
);

    localparam int MODE_W = 2 * NUM_FAULTS;
    localparam int NUM_CH = 2;

    typedef struct packed {
        logic [NUM_FAULTS-1:0] fault_prev;
    } edge_t;

    logic [MODE_W-1:0]     mode;
    logic                  rel_zero;
    act_set_t              cbc_act, ost_act;
    logic                  ost_clr;
    logic [NUM_FAULTS-1:0] cbc_hit, ost_hit, rise;
    logic                  cbc_rel;
    logic [NUM_CH-1:0]     raw_vec, out_vec;
    edge_t                 edge_d, edge_q;

    trip_cfg_regs #(
        .NUM_FAULTS(NUM_FAULTS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (cfg_we_i),
        .addr_i    (cfg_addr_i),
        .wdata_i   (cfg_wdata_i),
        .mode_o    (mode),
        .rel_zero_o(rel_zero),
        .cbc_act_o (cbc_act),
        .ost_act_o (ost_act),
        .ost_clr_o (ost_clr)
    );

    for (genvar f = 0; f < NUM_FAULTS; f++) begin : g_fault
        assign cbc_hit[f] = fault_i[f] && (mode[2*f +: 2] == TRIP_CBC);
        assign ost_hit[f] = fault_i[f] && (mode[2*f +: 2] == TRIP_OST);
    end

    always_comb begin
        edge_d.fault_prev = fault_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= edge_d;
    end

    assign rise      = fault_i & ~edge_q.fault_prev;
    assign cbc_irq_o = rise & cbc_hit;
    assign ost_irq_o = rise & ost_hit;
    assign cbc_rel   = rel_zero ? evt_zero_i : evt_period_i;

    trip_latch i_cbc_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(|cbc_hit),
        .rel_i(cbc_rel),
        .on_o (cbc_active_o)
    );

    trip_latch i_ost_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(|ost_hit),
        .rel_i(ost_clr),
        .on_o (ost_active_o)
    );

    assign raw_vec = {pwm_b_i, pwm_a_i};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        trip_override i_ovr (
            .raw_i   (raw_vec[c]),
            .up_i    (cnt_up_i),
            .cbc_on_i(cbc_active_o),
            .ost_on_i(ost_active_o),
            .cbc_up_i(c == 0 ? cbc_act.a_up : cbc_act.b_up),
            .cbc_dn_i(c == 0 ? cbc_act.a_dn : cbc_act.b_dn),
            .ost_up_i(c == 0 ? ost_act.a_up : ost_act.b_up),
            .ost_dn_i(c == 0 ? ost_act.a_dn : ost_act.b_dn),
            .out_o   (out_vec[c])
        );
    end

    assign pwm_a_o = out_vec[0];
    assign pwm_b_o = out_vec[1];

    AST_PASS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cbc_active_o && !ost_active_o) |-> (pwm_a_o == pwm_a_i && pwm_b_o == pwm_b_i))
        else $error("override while idle"); // R3

    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cbc_irq_o != '0) |=> ((cbc_irq_o & $past(cbc_irq_o)) == '0))
        else $error("cbc irq longer than one cycle"); // R9

    AST_IRQ_ONE_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        (cbc_irq_o & ost_irq_o) == '0) else $error("fault raised both irq types"); // R1

    AST_IRQ_MEANS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ost_irq_o != '0) |-> ost_active_o) else $error("ost irq without trip"); // R8

endmodule

// File: tb/test_pwm_trip_guard.sv
module test_pwm_trip_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] fault_i = '0;
    logic       pwm_a_i = 1'b0, pwm_b_i = 1'b0, cnt_up_i = 1'b0;
    logic       evt_period_i = 1'b0, evt_zero_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [1:0] cfg_addr_i = '0;
    logic [7:0] cfg_wdata_i = '0;
    logic       pwm_a_o, pwm_b_o, cbc_active_o, ost_active_o;
    logic [2:0] cbc_irq_o, ost_irq_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // reference state
    logic [5:0] m_mode = '0;
    logic       m_sel = 1'b0;
    logic [7:0] m_cact = '0, m_oact = '0;
    logic       m_cbc = 1'b0, m_ost = 1'b0;
    logic [2:0] m_prev = '0;

    always #5 clk = ~clk;

    pwm_trip_guard i_pwm_trip_guard (
        .clk(clk), .rst_n(rst_n), .fault_i(fault_i),
        .pwm_a_i(pwm_a_i), .pwm_b_i(pwm_b_i), .cnt_up_i(cnt_up_i),
        .evt_period_i(evt_period_i), .evt_zero_i(evt_zero_i),
        .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
        .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o),
        .cbc_active_o(cbc_active_o), .ost_active_o(ost_active_o),
        .cbc_irq_o(cbc_irq_o), .ost_irq_o(ost_irq_o)
    );

    function automatic logic do_act(input logic [1:0] code, input logic raw);
        case (code)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~raw;
            default: return raw;
        endcase
    endfunction

    function automatic logic [1:0] field(input logic [7:0] set, input bit is_b, input logic up);
        int idx;
        idx = (is_b ? 4 : 0) + (up ? 0 : 2);
        return set[idx +: 2];
    endfunction

    task automatic cmp(input string tag, input string name, input logic [2:0] act, input logic [2:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, name, act, exp, $time);
        end
    endtask

    // drive one cycle, check combinational outputs, advance model
    task automatic cyc(input string tag, input logic [2:0] f, input logic a, input logic b,
                       input logic up, input logic tep, input logic tez,
                       input logic we, input logic [1:0] addr, input logic [7:0] data);
        logic [2:0] c_hit, o_hit, e_cirq, e_oirq;
        logic c_on, o_on, e_a, e_b, rel;
        @(negedge clk);
        fault_i = f; pwm_a_i = a; pwm_b_i = b; cnt_up_i = up;
        evt_period_i = tep; evt_zero_i = tez;
        cfg_we_i = we; cfg_addr_i = addr; cfg_wdata_i = data;
        #2;
        for (int i = 0; i < 3; i++) begin
            c_hit[i] = f[i] && (m_mode[2*i +: 2] == 2'b01);
            o_hit[i] = f[i] && (m_mode[2*i +: 2] == 2'b10);
        end
        c_on = m_cbc | (|c_hit);
        o_on = m_ost | (|o_hit);
        if (o_on) begin
            e_a = do_act(field(m_oact, 0, up), a);
            e_b = do_act(field(m_oact, 1, up), b);
        end else if (c_on) begin
            e_a = do_act(field(m_cact, 0, up), a);
            e_b = do_act(field(m_cact, 1, up), b);
        end else begin
            e_a = a; e_b = b;
        end
        e_cirq = c_hit & ~m_prev;
        e_oirq = o_hit & ~m_prev;
        cmp({tag, "/R3"}, "pwm_a", {2'b0, pwm_a_o}, {2'b0, e_a});
        cmp({tag, "/R3"}, "pwm_b", {2'b0, pwm_b_o}, {2'b0, e_b});
        cmp({tag, "/R8"}, "status", {1'b0, ost_active_o, cbc_active_o}, {1'b0, o_on, c_on});
        cmp({tag, "/R9"}, "cbc_irq", cbc_irq_o, e_cirq);
        cmp({tag, "/R9"}, "ost_irq", ost_irq_o, e_oirq);
        // model update for the coming edge
        rel = m_sel ? tez : tep;
        if (|c_hit) m_cbc = 1'b1; else if (rel) m_cbc = 1'b0;
        if (|o_hit) m_ost = 1'b1;
        else if (we && addr == 2'd3 && data[0]) m_ost = 1'b0;
        m_prev = f;
        if (we) begin
            case (addr)
                2'd0: begin m_mode = data[5:0]; m_sel = data[6]; end
                2'd1: m_cact = data;
                2'd2: m_oact = data;
                default: ;
            endcase
        end
    endtask

    task automatic idle(input string tag, input logic [2:0] f, input logic tep, input logic tez);
        cyc(tag, f, 1'($urandom), 1'($urandom), 1'($urandom), tep, tez, 1'b0, 2'd0, 8'h00);
    endtask

    task automatic wr(input string tag, input logic [1:0] addr, input logic [7:0] data);
        cyc(tag, 3'b000, 1'($urandom), 1'($urandom), 1'($urandom), 1'b0, 1'b0, 1'b1, addr, data);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11: reset state, faults ignored with all modes zero
        for (int i = 0; i < 4; i++) idle("R11", 3'b000, 1'b0, 1'b0);
        idle("R11", 3'b111, 1'b0, 1'b0);
        idle("R11", 3'b000, 1'b0, 1'b0);

        // configure: f0 cbc, f1 ost, f2 none, release at period end
        wr("R1", 2'd0, 8'h09);
        wr("R3", 2'd1, 8'h39);
        wr("R3", 2'd2, 8'h96);

        // R2/R10: single-cycle pulse on f0 trips at once and persists
        idle("R2", 3'b001, 1'b0, 1'b0);
        idle("R10", 3'b000, 1'b0, 1'b0);
        idle("R10", 3'b000, 1'b0, 1'b0);
        // R4: zero event not selected, no release; period end releases
        idle("R4", 3'b000, 1'b0, 1'b1);
        idle("R4", 3'b000, 1'b0, 1'b0);
        idle("R4", 3'b000, 1'b1, 1'b0);
        idle("R4", 3'b000, 1'b0, 1'b0);
        // R5: fault still present at release event
        idle("R5", 3'b001, 1'b0, 1'b0);
        idle("R5", 3'b001, 1'b1, 1'b0);
        idle("R5", 3'b000, 1'b0, 1'b0);
        idle("R5", 3'b000, 1'b1, 1'b0);
        idle("R5", 3'b000, 1'b0, 1'b0);

        // R6: one-shot latched through events, clear with fault present holds
        idle("R6", 3'b010, 1'b0, 1'b0);
        idle("R6", 3'b000, 1'b1, 1'b1);
        idle("R6", 3'b000, 1'b0, 1'b0);
        cyc("R6", 3'b010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 8'h01);
        idle("R6", 3'b000, 1'b0, 1'b0);
        wr("R6", 2'd3, 8'h01);
        idle("R6", 3'b000, 1'b0, 1'b0);

        // R7: both active, one-shot wins in both directions
        idle("R7", 3'b011, 1'b0, 1'b0);
        cyc("R7", 3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        cyc("R7", 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        wr("R7", 2'd3, 8'h01);
        idle("R7", 3'b000, 1'b1, 1'b0);

        // R1: code 11 and 00 ignore faults
        wr("R1", 2'd0, 8'h3F & 8'h33);
        idle("R1", 3'b111, 1'b0, 1'b0);
        idle("R1", 3'b000, 1'b1, 1'b0);

        // R4: release at zero event selected
        wr("R4", 2'd0, 8'h41);
        idle("R4", 3'b001, 1'b0, 1'b0);
        idle("R4", 3'b000, 1'b1, 1'b0);
        idle("R4", 3'b000, 1'b0, 1'b1);
        idle("R4", 3'b000, 1'b0, 1'b0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] f;
            logic we;
            f[0] = ($urandom_range(0, 5) == 0);
            f[1] = ($urandom_range(0, 9) == 0);
            f[2] = ($urandom_range(0, 7) == 0);
            we = ($urandom_range(0, 29) == 0);
            cyc("RND", f, 1'($urandom), 1'($urandom), 1'($urandom),
                ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                we, 2'($urandom), 8'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule